// File: doc/BRIEF.md
# Windowed Watchdog with Early Warning

The block is a window watchdog with a 7-bit down-counter, clocked from the bus clock through a prescaler and a selectable timer base. Software arms it by setting an activation bit. From then on it must reload the counter within a window. A reload is legal only while the counter is at or below a programmed window value. The reloaded value must keep the counter's top bit set. If the counter is allowed to run down past its top bit, or a reload breaks the window rule, the block raises a reset request. That request stays high until the block itself is reset.

One count step before the timeout, the block sets an early-warning flag. That flag can drive an interrupt output so that software gets a last chance to act. Software clears the flag by writing zero to it.

Access is through a small single-cycle register port with three registers:
- control: bits 6:0 are the counter, bit 7 is activation.
- configuration: bits 6:0 are the window, bits 8:7 are the timer base, bit 9 is the warning-interrupt enable.
- status: bit 0 is the warning flag.

The interrupt controller and the system reset logic that use the two outputs lie outside the block.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control reads 0x07F, configuration reads 0x07F, status reads 0, and both `rst_req_o` and `irq_o` are low.
- R2: The counter decrements by one every PRE_DIV × 2^tb bus cycles, where tb is configuration bits 8:7 (codes 0..3), counted from reset. Steps wrap 0x00 to 0x7F.
- R3: A write to control (address 0) loads the counter from bits 6:0. Writing 1 to bit 7 sets activation. Writing 0 to bit 7 never clears it.
- R4: While active, a count step from 0x40 to 0x3F sets `rst_req_o` on the following cycle. `rst_req_o` then stays high until `rst_ni` is asserted.
- R5: While active, a write to control when the current counter is greater than the window value (configuration bits 6:0) sets `rst_req_o`.
- R6: A control write whose bit 6 is 0 sets `rst_req_o` when the block is active or when that same write sets activation.
- R7: While active, a count step from 0x41 to 0x40 sets the warning flag (status bit 0).
- R8: Writing status (address 2) with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged.
- R9: `irq_o` is high exactly when the warning flag and configuration bit 9 are both set.
- R10: Reads are combinational on `addr_i`: 0 returns {active, counter}, 1 returns configuration, 2 returns status, 3 returns 0. Writes to address 3 change nothing.
- R11: While not active, the counter runs through 0x40 and wraps without setting `rst_req_o` or the flag.

Top module ports, in order: `win_watchdog`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Read data of the selected register |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
A wrong prescaler or timer-base phase shows up in the control read-back within one count period, as a step landing on the wrong cycle. A corrupted window or activation state shows up at `rst_req_o` on the cycle after the offending reload or count step. Because the request is sticky, any spurious assertion stays visible for the rest of the run. A flag that is set or cleared wrongly shows up at `irq_o` in the same cycle as the flag register changes.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int unsigned CNT_W  = 7;
  localparam int unsigned TB_W   = 2;
  localparam int unsigned DATA_W = CNT_W + TB_W + 1;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             ewi_en;
    logic [TB_W-1:0]  tb;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wwd_tick.sv
module wwd_tick #(
  parameter int unsigned PRE_DIV = 4096,
  parameter int unsigned TB_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_i,
  output logic            tick_o
);
  localparam int unsigned PRE_W  = $clog2(PRE_DIV);
  localparam int unsigned BASE_W = (1 << TB_W) - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] mask;
  logic              pre_wrap;

  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));
  assign mask     = (BASE_W'(1) << tb_i) - BASE_W'(1);
  assign tick_o   = pre_wrap && ((base_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      base_q <= '0;
    end else begin
      pre_q  <= pre_wrap ? '0 : pre_q + PRE_W'(1);
      base_q <= base_q + BASE_W'(pre_wrap);
    end
  end

  generate
    if (PRE_DIV > 1) begin : g_spacing
      p_tick_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             act_set_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             warn_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] BND  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WARN = BND + CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic active_q, rst_q;
  logic step, early_load, bad_val, under;

  assign step       = tick_i && !load_i;
  assign early_load = active_q && load_i && (cnt_q > win_i);
  assign bad_val    = (active_q || act_set_i) && load_i && !load_val_i[CNT_W-1];
  assign under      = active_q && step && (cnt_q == BND);
  assign warn_o     = active_q && step && (cnt_q == WARN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '1;
      active_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (load_i)    cnt_q <= load_val_i;
      else if (step) cnt_q <= cnt_q - CNT_W'(1);
      active_q <= active_q | (load_i & act_set_i);
      rst_q    <= rst_q | early_load | bad_val | under;
    end
  end

  assign cnt_o     = cnt_q;
  assign active_o  = active_q;
  assign rst_req_o = rst_q;

  p_active_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> active_q);
  p_rst_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> rst_q);
  p_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && tick_i && !load_i && cnt_q == BND) |=> rst_req_o);
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wwd_flag.sv
module wwd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int unsigned PRE_DIV = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  cfg_t             cfg_q;
  reg_sel_e         sel;
  logic             wr_ctrl, wr_cfg, wr_stat;
  logic             tick, warn, flag, active;
  logic [CNT_W-1:0] cnt;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_ctrl = wr_en_i && (sel == REG_CTRL);
  assign wr_cfg  = wr_en_i && (sel == REG_CFG);
  assign wr_stat = wr_en_i && (sel == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.win    <= '1;
      cfg_q.tb     <= '0;
      cfg_q.ewi_en <= 1'b0;
    end else if (wr_cfg) begin
      cfg_q <= cfg_t'(wdata_i);
    end
  end

  wwd_tick #(.PRE_DIV(PRE_DIV), .TB_W(TB_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tb_i   (cfg_q.tb),
    .tick_o (tick)
  );

  wwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (wr_ctrl),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .act_set_i  (wdata_i[CNT_W]),
    .win_i      (cfg_q.win),
    .cnt_o      (cnt),
    .active_o   (active),
    .warn_o     (warn),
    .rst_req_o  (rst_req_o)
  );

  wwd_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (warn),
    .clr_i  (wr_stat && !wdata_i[0]),
    .flag_o (flag)
  );

  assign irq_o = flag && cfg_q.ewi_en;

  always_comb begin
    unique case (sel)
      REG_CTRL: rdata_o = DATA_W'({active, cnt});
      REG_CFG:  rdata_o = cfg_q;
      REG_STAT: rdata_o = DATA_W'(flag);
      default:  rdata_o = '0;
    endcase
  end

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(cfg_q));
endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;
  logic       irq, rst_req;

  int n_cmp = 0, n_bad = 0;

  win_watchdog #(.PRE_DIV(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  always #5 clk = ~clk;

  // behavioural reference
  logic [6:0] m_cnt, m_win;
  logic [1:0] m_tb;
  logic       m_act, m_ewi, m_flag, m_rq;
  int         m_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 7'h7F; m_win = 7'h7F; m_tb = 0; m_act = 0;
      m_ewi = 0; m_flag = 0; m_rq = 0; m_n = 0;
    end else begin
      bit tk;
      tk = ((m_n + 1) % (P << m_tb)) == 0;
      m_n++;
      if (wr_en && addr == 2'd2 && !wdata[0]) m_flag = 0;
      if (wr_en && addr == 2'd0) begin
        if (m_act && m_cnt > m_win) m_rq = 1;
        if ((m_act || wdata[7]) && !wdata[6]) m_rq = 1;
        m_act = m_act | wdata[7];
        m_cnt = wdata[6:0];
      end else if (tk) begin
        if (m_act && m_cnt == 7'h40) m_rq = 1;
        if (m_act && m_cnt == 7'h41) m_flag = 1;
        m_cnt = m_cnt - 7'd1;
      end
      if (wr_en && addr == 2'd1) begin
        m_win = wdata[6:0]; m_tb = wdata[8:7]; m_ewi = wdata[9];
      end
    end
  end

  function automatic logic [9:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {2'b0, m_act, m_cnt};
      2'd1: return {m_ewi, m_tb, m_win};
      2'd2: return {9'b0, m_flag};
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R10 rdata", rdata, m_read(addr));
    chk("R4 rst_req", rst_req, m_rq);
    chk("R9 irq", irq, m_flag & m_ewi);
  end

  task automatic do_reset();
    @(posedge clk); #2; rst_n = 0; wr_en = 0; addr = 0;
    repeat (2) @(posedge clk); #2; rst_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [9:0] d);
    @(posedge clk); #2; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [9:0] v);
    @(posedge clk); #2; addr = a;
    @(negedge clk); v = rdata;
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] v;
    int t0, t1, cyc;
    // R1: values held during reset
    rst_n = 0;
    for (int a = 0; a < 3; a++) begin
      @(posedge clk); #2; addr = 2'(a);
      @(negedge clk);
      chk("R1 reset read", rdata, (a == 2) ? 10'h0 : 10'h07F);
    end
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    @(posedge clk); #2; rst_n = 1;

    // R11: inactive run through the boundary and wrap
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk("R11 no reset inactive", rst_req, 0);
    rd(2'd2, v); chk("R11 no flag inactive", v, 0);

    // R2: step spacing with tb=2
    do_reset();
    wr(2'd1, 10'h17F);
    wr(2'd0, 10'h050);
    @(posedge clk); #2; addr = 0;
    @(negedge clk); v = rdata; cyc = 0; t0 = -1; t1 = -1;
    while (t1 < 0 && cyc < 200) begin
      @(negedge clk); cyc++;
      if (rdata != v) begin
        if (t0 < 0) t0 = cyc; else t1 = cyc;
        v = rdata;
      end
    end
    chk("R2 step period", t1 - t0, P * 4);

    // R3: activation is sticky
    do_reset();
    wr(2'd0, 10'h0FF);
    wr(2'd0, 10'h07F);
    rd(2'd0, v); chk("R3 active sticky", v[7], 1);
    chk("R3 no reset legal", rst_req, 0);

    // R5: reload above window
    do_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0C5);
    wr(2'd0, 10'h0FF);
    @(negedge clk); chk("R5 no reset yet", rst_req, 0);
    wr(2'd0, 10'h0C5);
    @(negedge clk); chk("R5 window violation", rst_req, 1);

    // R6: activating write with bit 6 clear
    do_reset();
    wr(2'd0, 10'h0BF);
    @(negedge clk); chk("R6 low value", rst_req, 1);

    // R7 R8 R9 R4: warning then timeout
    do_reset();
    wr(2'd1, 10'h3D0);
    wr(2'd0, 10'h0C5);
    wr(2'd0, 10'h0C5);
    @(negedge clk); chk("R5 legal reload", rst_req, 0);
    @(posedge clk); #2; addr = 0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (rdata != 10'h0C0 && cyc < 1000);
    rd(2'd2, v); chk("R7 flag set", v, 1);
    chk("R9 irq on", irq, 1);
    wr(2'd2, 10'h001);
    rd(2'd2, v); chk("R8 write one keeps", v, 1);
    wr(2'd2, 10'h000);
    rd(2'd2, v); chk("R8 cleared", v, 0);
    chk("R9 irq off", irq, 0);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rst_req && cyc < 1000);
    rd(2'd0, v); chk("R4 timeout at boundary", v, 10'h0BF);

    // R10: spare address
    do_reset();
    wr(2'd3, 10'h3FF);
    rd(2'd3, v); chk("R10 spare reads zero", v, 0);
    rd(2'd1, v); chk("R10 cfg untouched", v, 10'h07F);
    rd(2'd0, v); chk("R10 ctrl active untouched", v[7], 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule